// File: doc/BRIEF.md
# Amplifier Fault Supervisor

This block collects the fault indications of a two-channel switching audio amplifier and decides, for each channel, whether the output stage may drive or must be held in high impedance. Its inputs are the fault flags raised by the analog detectors. Per channel, these are DC offset, overcurrent and cycle-by-cycle current limit. Shared by both channels are supply overvoltage, supply undervoltage, audio clock error and over-temperature. Every flag passes through a synchronizer before the block uses it.

Faults come in two recovery classes. Clock errors and supply excursions are self-recovering. The outputs go to high impedance only while the synchronized flag is high, and they come back without software action. The status bit for these faults still stays set until software clears it. DC, overcurrent, cycle-by-cycle and thermal faults are latched. The affected outputs stay off until software writes the clear command. If a condition is still present when the clear is written, the block reports it again in the same cycle the other bits clear, and the shutdown holds. Software reads three status registers and issues the clear command over a simple register bus. A combined fault output is provided for use as an interrupt.

Top module: `amp_fault_supervisor`

## Requirements
- R1: After reset, all status bits are 0, `hiz_o` is 2'b00 and `fault_any_o` is 0.
- R2: The bus reads status combinationally from `bus_addr_i`.
  - Address 0x70: bit0 is left DC, bit1 is right DC, bit2 is left overcurrent, bit3 is right overcurrent.
  - Address 0x71: bit0 is supply overvoltage, bit1 is supply undervoltage, bit2 is clock error.
  - Address 0x72: bit0 is left cycle-by-cycle, bit1 is right cycle-by-cycle, bit2 is over-temperature.
  - Every other address, 0x78 included, and every unused bit read as 0.
  - Channel index 0 is left.
- R3: A fault flag is delayed by SYNC_STAGES flops. A flag that is high at posedge k sets its status bit at posedge k+SYNC_STAGES. A pulse of one cycle is enough to set it.
- R4: A status bit stays set after its flag returns low, until a clear command.
- R5: A clear command is a write to 0x78 with bit7 = 1. At the next edge every status bit takes the value of its synchronized flag: bits whose condition is gone return to 0, and bits whose condition persists stay at 1.
- R6: A write to 0x78 with bit7 = 0, or a write of 0x80 to any other address, leaves every status bit and `hiz_o` unchanged.
- R7: While the synchronized clock-error, supply-overvoltage or supply-undervoltage flag is high, both `hiz_o` bits are 1. They return to 0 once the flag is low, with no write needed.
- R8: Each of the left and right DC, overcurrent and cycle-by-cycle status bits holds only its own channel's `hiz_o` bit at 1, until a clear command removes it.
- R9: The over-temperature status bit holds both `hiz_o` bits at 1 until a clear command removes it.
- R10: `fault_any_o` is 1 exactly when any status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dc_fault_i | input | 2 | DC offset fault per channel (0 = left) |
| oc_fault_i | input | 2 | Overcurrent shutdown fault per channel |
| cbc_fault_i | input | 2 | Cycle-by-cycle current limit fault per channel |
| sup_ov_i | input | 1 | Supply overvoltage |
| sup_uv_i | input | 1 | Supply undervoltage |
| clk_err_i | input | 1 | Audio clock error |
| over_temp_i | input | 1 | Over-temperature |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| hiz_o | output | 2 | Per-channel output shutdown (1 = high impedance) |
| fault_any_o | output | 1 | Any status bit set |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. Its model delays the flags through a queue sized from that same parameter, so the flag-to-status latency is checked against the exact edge count. With that short pipeline, a one-cycle fault pulse is enough to show stickiness and the two recovery classes. A clear written while a fault is still held shows the immediate re-report. The read mux and both channel outputs are compared against the model on every cycle.

// File: rtl/amp_fault_pkg.sv
package amp_fault_pkg;
    localparam int NCH     = 2;
    localparam int AW      = 8;
    localparam int DW      = 8;
    localparam int CLR_BIT = 7;

    localparam logic [AW-1:0] ADDR_CHAN = 8'h70;
    localparam logic [AW-1:0] ADDR_GLB1 = 8'h71;
    localparam logic [AW-1:0] ADDR_GLB2 = 8'h72;
    localparam logic [AW-1:0] ADDR_CLR  = 8'h78;

    typedef struct packed {
        logic           ot;
        logic           clk_err;
        logic           sup_uv;
        logic           sup_ov;
        logic [NCH-1:0] cbc;
        logic [NCH-1:0] oc;
        logic [NCH-1:0] dc;
    } flt_t;

    localparam int FLT_W = $bits(flt_t);
endpackage

// File: rtl/amp_fault_sync.sv
module amp_fault_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.pipe[STAGES-1];

    initial begin
        stages_param_chk: assert (STAGES >= 2);
    end
endmodule

// File: rtl/amp_fault_regfile.sv
module amp_fault_regfile
    import amp_fault_pkg::*;
(
    input  flt_t          stat_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          we_i,
    output logic [DW-1:0] rdata_o,
    output logic          clr_o
);
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_CHAN: begin
                rdata_o[NCH-1:0]     = stat_i.dc;
                rdata_o[2*NCH-1:NCH] = stat_i.oc;
            end
            ADDR_GLB1: begin
                rdata_o[0] = stat_i.sup_ov;
                rdata_o[1] = stat_i.sup_uv;
                rdata_o[2] = stat_i.clk_err;
            end
            ADDR_GLB2: begin
                rdata_o[NCH-1:0] = stat_i.cbc;
                rdata_o[NCH]     = stat_i.ot;
            end
            default: rdata_o = '0;
        endcase
    end

    assign clr_o = we_i && (addr_i == ADDR_CLR) && wdata_i[CLR_BIT];
endmodule

// File: rtl/amp_fault_core.sv
module amp_fault_core
    import amp_fault_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  flt_t           live_i,
    input  logic           clr_i,
    output flt_t           stat_o,
    output logic [NCH-1:0] hiz_o,
    output logic           fault_any_o
);
    typedef struct packed {
        flt_t stat;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     auto_off;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.stat = live_i;
        else       st_d.stat = flt_t'(st_q.stat | live_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign auto_off = live_i.clk_err | live_i.sup_ov | live_i.sup_uv;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            hiz_o[c] = st_q.stat.dc[c] | st_q.stat.oc[c] | st_q.stat.cbc[c]
                     | st_q.stat.ot | auto_off;
        end
    end

    assign stat_o      = st_q.stat;
    assign fault_any_o = |st_q.stat;

    logic [FLT_W-1:0] stat_bits, live_bits;
    assign stat_bits = st_q.stat;
    assign live_bits = live_i;

    // R3
    sync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|live_bits) |=> ((stat_bits & $past(live_bits)) == $past(live_bits)));

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((stat_bits & $past(stat_bits)) == $past(stat_bits)));

    // R5
    clear_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (stat_bits == $past(live_bits)));

    // R9
    thermal_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat.ot && !clr_i) |=> (&hiz_o));

    for (genvar c = 0; c < NCH; c++) begin : g_ch_chk
        // R8
        latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((st_q.stat.dc[c] | st_q.stat.oc[c] | st_q.stat.cbc[c]) && !clr_i)
            |=> hiz_o[c]);
    end
endmodule

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor
    import amp_fault_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] dc_fault_i,
    input  logic [NCH-1:0] oc_fault_i,
    input  logic [NCH-1:0] cbc_fault_i,
    input  logic           sup_ov_i,
    input  logic           sup_uv_i,
    input  logic           clk_err_i,
    input  logic           over_temp_i,
    input  logic [AW-1:0]  bus_addr_i,
    input  logic [DW-1:0]  bus_wdata_i,
    input  logic           bus_we_i,
    output logic [DW-1:0]  bus_rdata_o,
    output logic [NCH-1:0] hiz_o,
    output logic           fault_any_o
);
    flt_t raw, live, stat;
    logic [FLT_W-1:0] live_vec;
    logic clr;

    always_comb begin
        raw         = '0;
        raw.dc      = dc_fault_i;
        raw.oc      = oc_fault_i;
        raw.cbc     = cbc_fault_i;
        raw.sup_ov  = sup_ov_i;
        raw.sup_uv  = sup_uv_i;
        raw.clk_err = clk_err_i;
        raw.ot      = over_temp_i;
    end

    amp_fault_sync #(.W(FLT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw),
        .sync_o (live_vec)
    );
    assign live = live_vec;

    amp_fault_regfile u_regs (
        .stat_i  (stat),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .we_i    (bus_we_i),
        .rdata_o (bus_rdata_o),
        .clr_o   (clr)
    );

    amp_fault_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .live_i      (live),
        .clr_i       (clr),
        .stat_o      (stat),
        .hiz_o       (hiz_o),
        .fault_any_o (fault_any_o)
    );

    logic [FLT_W-1:0] stat_vec;
    assign stat_vec = stat;

    // R6
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == ADDR_CLR && !bus_wdata_i[CLR_BIT])
        |=> ((stat_vec & $past(stat_vec)) == $past(stat_vec)));

    // R7
    auto_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!live.clk_err && !live.sup_ov && !live.sup_uv && stat.ot == 1'b0 &&
         stat.dc == '0 && stat.oc == '0 && stat.cbc == '0) |-> (hiz_o == '0));
endmodule

// File: tb/amp_fault_supervisor_bench.sv
module amp_fault_supervisor_bench;
    import amp_fault_pkg::*;

    localparam int SYNC_STAGES = 2;
    localparam int WATCHDOG    = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    flt_t raw = '0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic we = 1'b0;
    logic [7:0] rdata;
    logic [1:0] hiz;
    logic fault_any;

    always #2 clk = ~clk;

    amp_fault_supervisor #(.SYNC_STAGES(SYNC_STAGES)) u_amp_fault_supervisor (
        .clk         (clk),
        .rst_n       (rst_n),
        .dc_fault_i  (raw.dc),
        .oc_fault_i  (raw.oc),
        .cbc_fault_i (raw.cbc),
        .sup_ov_i    (raw.sup_ov),
        .sup_uv_i    (raw.sup_uv),
        .clk_err_i   (raw.clk_err),
        .over_temp_i (raw.ot),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_we_i    (we),
        .bus_rdata_o (rdata),
        .hiz_o       (hiz),
        .fault_any_o (fault_any)
    );

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";

    // reference model: delay queue of raw samples plus sticky status word
    flt_t q[$];
    flt_t m_stat = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q = {};
            for (int i = 0; i < SYNC_STAGES; i++) q.push_back('0);
            m_stat = '0;
        end else begin
            flt_t used;
            used = q.pop_front();
            if (we && addr == 8'h78 && wdata[7]) m_stat = used;
            else                                 m_stat = flt_t'(m_stat | used);
            q.push_back(raw);
        end
    end

    function automatic logic [7:0] exp_rdata(logic [7:0] a);
        logic [7:0] r = 8'h00;
        if (a == 8'h70) r = {4'b0, m_stat.oc[1], m_stat.oc[0], m_stat.dc[1], m_stat.dc[0]};
        if (a == 8'h71) r = {5'b0, m_stat.clk_err, m_stat.sup_uv, m_stat.sup_ov};
        if (a == 8'h72) r = {5'b0, m_stat.ot, m_stat.cbc[1], m_stat.cbc[0]};
        return r;
    endfunction

    function automatic logic [1:0] exp_hiz();
        logic [1:0] h;
        logic live_auto;
        live_auto = (q.size() > 0) && (q[0].clk_err | q[0].sup_ov | q[0].sup_uv);
        for (int c = 0; c < 2; c++) begin
            h[c] = m_stat.dc[c] | m_stat.oc[c] | m_stat.cbc[c] | m_stat.ot | live_auto;
        end
        return h;
    endfunction

    task automatic chk(string req, string what, int got, int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic compare();
        chk(cur_req, "hiz", int'(hiz), int'(exp_hiz()));
        chk(cur_req, "rdata", int'(rdata), int'(exp_rdata(addr)));
        chk("R10", "fault_any", int'(fault_any), int'(|m_stat));
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        cyc(1);
        we = 1'b0; wdata = 8'h00;
    endtask

    task automatic scenario();
        // R1: reset state
        cur_req = "R1";
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk("R1", "hiz after reset", int'(hiz), 0);

        // R3: one-cycle left DC pulse becomes visible after the sync delay
        cur_req = "R3";
        addr = 8'h70;
        raw.dc[0] = 1'b1;
        cyc(1);
        raw.dc[0] = 1'b0;
        cyc(3);
        chk("R3", "0x70 after pulse", int'(rdata), 'h01);

        // R4: sticky, R8: only left channel held off
        cur_req = "R4";
        cyc(5);
        chk("R4", "0x70 sticky", int'(rdata), 'h01);
        cur_req = "R8";
        cyc(2);
        chk("R8", "left only hiz", int'(hiz), 'h1);

        // R6: ignored writes
        cur_req = "R6";
        bus_write(8'h78, 8'h7F);
        bus_write(8'h77, 8'h80);
        addr = 8'h70;
        cyc(2);
        chk("R6", "0x70 after ignored writes", int'(rdata), 'h01);
        chk("R6", "hiz after ignored writes", int'(hiz), 'h1);

        // R5: clear removes a gone condition
        cur_req = "R5";
        bus_write(8'h78, 8'h80);
        addr = 8'h70;
        cyc(1);
        chk("R5", "0x70 after clear", int'(rdata), 'h00);
        chk("R5", "hiz after clear", int'(hiz), 'h0);

        // R5: clear while right overcurrent persists re-reports it
        raw.oc[1] = 1'b1;
        cyc(4);
        bus_write(8'h78, 8'h80);
        addr = 8'h70;
        cyc(1);
        chk("R5", "0x70 persistent oc", int'(rdata), 'h08);
        chk("R8", "right only hiz", int'(hiz), 'h2);
        raw.oc[1] = 1'b0;
        cyc(4);
        bus_write(8'h78, 8'h80);
        cyc(2);

        // R7: clock error auto-recovers, status bit sticky
        cur_req = "R7";
        addr = 8'h71;
        raw.clk_err = 1'b1;
        cyc(4);
        chk("R7", "hiz during clock error", int'(hiz), 'h3);
        raw.clk_err = 1'b0;
        cyc(4);
        chk("R7", "hiz after clock recovery", int'(hiz), 'h0);
        chk("R4", "0x71 clock bit sticky", int'(rdata), 'h04);
        raw.sup_uv = 1'b1;
        cyc(3);
        raw.sup_uv = 1'b0;
        raw.sup_ov = 1'b1;
        cyc(3);
        raw.sup_ov = 1'b0;
        cyc(4);
        chk("R7", "0x71 supply bits", int'(rdata), 'h07);
        bus_write(8'h78, 8'hFF);
        addr = 8'h71;
        cyc(1);

        // R9: thermal latches both channels
        cur_req = "R9";
        addr = 8'h72;
        raw.ot = 1'b1;
        cyc(2);
        raw.ot = 1'b0;
        cyc(6);
        chk("R9", "0x72 thermal", int'(rdata), 'h04);
        chk("R9", "both hiz", int'(hiz), 'h3);

        // R2: unmapped and clear-register reads
        cur_req = "R2";
        raw.cbc[1] = 1'b1;
        cyc(1);
        raw.cbc[1] = 1'b0;
        cyc(3);
        chk("R2", "0x72 cbc+ot", int'(rdata), 'h06);
        addr = 8'h78;
        cyc(1);
        chk("R2", "0x78 reads zero", int'(rdata), 'h00);
        addr = 8'h73;
        cyc(1);
        chk("R2", "0x73 reads zero", int'(rdata), 'h00);

        // R10: combined flag drops after the final clear
        cur_req = "R10";
        chk("R10", "fault_any set", int'(fault_any), 1);
        bus_write(8'h78, 8'h80);
        addr = 8'h72;
        cyc(2);
        chk("R10", "fault_any clear", int'(fault_any), 0);
        chk("R9", "hiz released", int'(hiz), 'h0);
    endtask

    initial begin
        fork
            scenario();
            begin
                repeat (WATCHDOG) @(posedge clk);
                miscompares++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule